// File: doc/BRIEF.md
# Delimiter and Length Packet Framer

This block sits behind a serial receiver and turns a plain stream of received words into packets. Each word comes with a one-cycle valid strobe. The block forwards the word one cycle later and adds three marks to it: a start-of-packet flag, an end-of-packet flag and the position of the word inside its packet. A packet ends on whichever happens first: a word that equals a configured delimiter value, or the packet reaching a configured word count. Either rule can be turned off. With both rules off the words pass through without marks.

The delimiter compare uses the whole received word, up to 9 bits wide. The delimiter word is the last word of the packet it closes. The configuration is captured when the first word of a packet arrives and is held until that packet closes. A controller can therefore change the settings at any time without splitting a packet that is already in progress. Idle cycles between words have no effect on the packet in progress. No timeout closes a packet.

Top module: `pkt_delim_framer`

## Requirements
- R1: While reset is low, and on the first clock after reset before any word is accepted, out_valid, out_sop and out_eop are 0.
- R2: Every accepted word (in_valid=1) appears on out_data with out_valid=1 exactly one clock later. out_valid is 0 in any cycle that does not follow an accepted word.
- R3: When at least one close rule is enabled, the first word after reset or after a closed packet has out_sop=1 and out_len=1.
- R4: With the delimiter rule enabled, a word whose full DATA_W-bit value equals cfg_delim has out_eop=1. A word that differs from the delimiter in any bit, including bit 8, does not close the packet by this rule.
- R5: With the length rule enabled, the word whose position reaches cfg_len has out_eop=1. A limit of 0 acts as a limit of 1.
- R6: With both rules enabled, the packet closes on whichever rule is met first.
- R7: With both rules disabled, out_sop=0, out_eop=0 and out_len=0 on every word.
- R8: Inside a packet out_len rises by one on each word and saturates at 2^LEN_W-1.
- R9: The rule enables, the delimiter and the limit are sampled on the first word of a packet. Changes made while the packet is open have no effect until the next packet.
- R10: A word that opens a packet and meets a close rule carries out_sop=1 and out_eop=1 together.
- R11: Idle cycles (in_valid=0) between words leave the open packet and its word count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | DATA_W | Received word |
| cfg_delim_en | input | 1 | Enable the delimiter close rule |
| cfg_delim | input | DATA_W | Delimiter value |
| cfg_len_en | input | 1 | Enable the length close rule |
| cfg_len | input | LEN_W | Packet word limit |
| out_valid | output | 1 | Output word strobe |
| out_data | output | DATA_W | Forwarded word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_len | output | LEN_W | Position of the word in its packet (0 when unframed) |

## Verification
Every wrong internal state shows at the ports on the next forwarded word. If the open flag is stuck set, a word that should start a packet comes out without out_sop. If it is stuck clear, every word comes out marked as a start. A bad word counter shows as an out_len that skips, repeats or wraps, and an early or late out_eop appears on the wrong word. If the configuration is not held, a change in the middle of a packet moves the closing word, and the first word after that change shows the error.

// File: rtl/pkt_delim_framer_pkg.sv
package pkt_delim_framer_pkg;

    // Default widths: a 9-bit received word and an 8-bit packet counter.
    localparam int unsigned DEF_DATA_W = 9;
    localparam int unsigned DEF_LEN_W  = 8;

endpackage

// File: rtl/pkt_cfg_hold.sv
// Keeps a copy of the close-rule settings for the packet that is open.
// Capture happens on the first word of a packet. While a packet is open,
// the held copy is used instead of the live inputs.
module pkt_cfg_hold #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              use_held,
    input  logic              live_delim_en,
    input  logic [DATA_W-1:0] live_delim,
    input  logic              live_len_en,
    input  logic [LEN_W-1:0]  live_len,
    output logic              eff_delim_en,
    output logic [DATA_W-1:0] eff_delim,
    output logic              eff_len_en,
    output logic [LEN_W-1:0]  eff_len
);

    typedef struct packed {
        logic              delim_en;
        logic [DATA_W-1:0] delim;
        logic              len_en;
        logic [LEN_W-1:0]  len;
    } cfg_t;

    cfg_t held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (capture) begin
            held_d.delim_en = live_delim_en;
            held_d.delim    = live_delim;
            held_d.len_en   = live_len_en;
            held_d.len      = live_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    always_comb begin
        if (use_held) begin
            eff_delim_en = held_q.delim_en;
            eff_delim    = held_q.delim;
            eff_len_en   = held_q.len_en;
            eff_len      = held_q.len;
        end else begin
            eff_delim_en = live_delim_en;
            eff_delim    = live_delim;
            eff_len_en   = live_len_en;
            eff_len      = live_len;
        end
    end

endmodule

// File: rtl/pkt_len_step.sv
// Works out the packet position of an incoming word. The count saturates.
module pkt_len_step #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             pkt_open,
    input  logic [LEN_W-1:0] count,
    output logic [LEN_W-1:0] next_count
);

    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};
    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    always_comb begin
        if (!pkt_open) begin
            next_count = CNT_ONE;
        end else if (count == CNT_MAX) begin
            next_count = CNT_MAX;
        end else begin
            next_count = count + CNT_ONE;
        end
    end

endmodule

// File: rtl/pkt_close_detect.sv
// Decides whether a word closes its packet. Either rule may close it.
module pkt_close_detect #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned LEN_W  = 8
) (
    input  logic              delim_en,
    input  logic [DATA_W-1:0] delim,
    input  logic              len_en,
    input  logic [LEN_W-1:0]  len_limit,
    input  logic [DATA_W-1:0] word,
    input  logic [LEN_W-1:0]  position,
    output logic              framing,
    output logic              close
);

    logic hit_delim;
    logic hit_len;

    always_comb begin
        framing   = delim_en | len_en;
        hit_delim = delim_en && (word == delim);
        // A limit of zero is reached as soon as position one is.
        hit_len   = len_en && (position >= len_limit);
        close     = hit_delim | hit_len;
    end

endmodule

// File: rtl/pkt_delim_framer.sv
module pkt_delim_framer
    import pkt_delim_framer_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned LEN_W  = DEF_LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_delim_en,
    input  logic [DATA_W-1:0] cfg_delim,
    input  logic              cfg_len_en,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [LEN_W-1:0]  out_len
);

    typedef struct packed {
        logic              pkt_open;
        logic [LEN_W-1:0]  count;
        logic              o_valid;
        logic [DATA_W-1:0] o_data;
        logic              o_sop;
        logic              o_eop;
        logic [LEN_W-1:0]  o_len;
    } state_t;

    state_t st_d, st_q;

    logic              eff_delim_en;
    logic [DATA_W-1:0] eff_delim;
    logic              eff_len_en;
    logic [LEN_W-1:0]  eff_len;
    logic [LEN_W-1:0]  next_count;
    logic              framing;
    logic              close;
    logic              capture;

    assign capture = in_valid && !st_q.pkt_open;

    pkt_cfg_hold #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture       (capture),
        .use_held      (st_q.pkt_open),
        .live_delim_en (cfg_delim_en),
        .live_delim    (cfg_delim),
        .live_len_en   (cfg_len_en),
        .live_len      (cfg_len),
        .eff_delim_en  (eff_delim_en),
        .eff_delim     (eff_delim),
        .eff_len_en    (eff_len_en),
        .eff_len       (eff_len)
    );

    pkt_len_step #(.LEN_W(LEN_W)) u_step (
        .pkt_open   (st_q.pkt_open),
        .count      (st_q.count),
        .next_count (next_count)
    );

    pkt_close_detect #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_close (
        .delim_en  (eff_delim_en),
        .delim     (eff_delim),
        .len_en    (eff_len_en),
        .len_limit (eff_len),
        .word      (in_data),
        .position  (next_count),
        .framing   (framing),
        .close     (close)
    );

    always_comb begin
        st_d         = st_q;
        st_d.o_valid = in_valid;
        st_d.o_sop   = 1'b0;
        st_d.o_eop   = 1'b0;
        if (in_valid) begin
            st_d.o_data = in_data;
            if (framing) begin
                st_d.o_sop = !st_q.pkt_open;
                st_d.o_eop = close;
                st_d.o_len = next_count;
                if (close) begin
                    st_d.pkt_open = 1'b0;
                    st_d.count    = '0;
                end else begin
                    st_d.pkt_open = 1'b1;
                    st_d.count    = next_count;
                end
            end else begin
                st_d.o_len = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_valid;
    assign out_data  = st_q.o_data;
    assign out_sop   = st_q.o_sop;
    assign out_eop   = st_q.o_eop;
    assign out_len   = st_q.o_len;

endmodule

// File: rtl/pkt_delim_framer_chk.sv
module pkt_delim_framer_chk #(
    parameter int unsigned LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic [LEN_W-1:0] out_len
);

    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    logic             prev_closed_q;
    logic [LEN_W-1:0] prev_len_q;
    logic             seen_clk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_closed_q <= 1'b1;
            prev_len_q    <= '0;
            seen_clk_q    <= 1'b0;
        end else begin
            seen_clk_q <= 1'b1;
            if (out_valid) begin
                prev_closed_q <= out_eop || (out_len == '0);
                prev_len_q    <= out_len;
            end
        end
    end

    // R2: packet marks appear only on a forwarded word
    assert_marks_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    // R2: a forwarded word follows an accepted word
    assert_out_follows_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_clk_q && out_valid) |-> $past(in_valid));

    // R3: a packet opens at position one
    assert_sop_len_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_len == LEN_W'(1)));

    // R3: a framed word after a closed packet opens a new one, and only then
    assert_open_after_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len != '0) |-> (out_sop == prev_closed_q));

    // R7: unframed words carry no marks
    assert_unframed_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == '0) |-> (!out_sop && !out_eop));

    // R8: position steps by one and saturates
    assert_len_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len != '0 && !out_sop) |->
        (out_len == ((prev_len_q == CNT_MAX) ? CNT_MAX : LEN_W'(prev_len_q + 1'b1))));

endmodule

bind pkt_delim_framer pkt_delim_framer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_len   (out_len)
);

// File: tb/tb_pkt_delim_framer.sv
module tb_pkt_delim_framer;

    localparam int DATA_W   = 9;
    localparam int LEN_W    = 8;
    localparam int CLK_PER  = 10;
    localparam int CNT_MAX  = (1 << LEN_W) - 1;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              cfg_delim_en = 1'b0;
    logic [DATA_W-1:0] cfg_delim = '0;
    logic              cfg_len_en = 1'b0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_sop;
    logic              out_eop;
    logic [LEN_W-1:0]  out_len;

    pkt_delim_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_delim_en(cfg_delim_en), .cfg_delim(cfg_delim),
        .cfg_len_en(cfg_len_en), .cfg_len(cfg_len),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_len(out_len)
    );

    always #(CLK_PER/2) clk = ~clk;

    typedef struct {
        int    data;
        bit    sop;
        bit    eop;
        int    len;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 0;

    // Reference model state
    bit m_open = 0;
    int m_cnt  = 0;
    bit h_de = 0, h_le = 0;
    int h_d = 0, h_l = 0;

    task automatic set_cfg(bit de, int d, bit le, int l);
        cfg_delim_en = de;
        cfg_delim    = DATA_W'(d);
        cfg_len_en   = le;
        cfg_len      = LEN_W'(l);
    endtask

    task automatic send(int d, string req, int gap = 0);
        exp_t e;
        int   pos;
        bit   cls;
        if (!m_open) begin
            h_de = cfg_delim_en; h_d = int'(cfg_delim);
            h_le = cfg_len_en;   h_l = int'(cfg_len);
        end
        e.data = d; e.req = req; e.sop = 0; e.eop = 0; e.len = 0;
        if (h_de || h_le) begin
            pos = m_open ? ((m_cnt == CNT_MAX) ? CNT_MAX : m_cnt + 1) : 1;
            cls = (h_de && d == h_d) || (h_le && pos >= h_l);
            e.sop = !m_open; e.eop = cls; e.len = pos;
            if (cls) begin m_open = 0; m_cnt = 0; end
            else begin m_open = 1; m_cnt = pos; end
        end
        exp_q.push_back(e);
        in_valid = 1'b1;
        in_data  = DATA_W'(d);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: compare each forwarded word with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R2", "unexpected output word", int'(out_data), -1);
            end else begin
                exp_t e;
                bit   ok;
                e  = exp_q.pop_front();
                ok = (int'(out_data) == e.data) && (out_sop == e.sop) &&
                     (out_eop == e.eop) && (int'(out_len) == e.len);
                n_checks++;
                if (!ok) begin
                    n_fails++;
                    $display("FAIL %s data/sop/eop/len actual %0h/%0d/%0d/%0d expected %0h/%0d/%0d/%0d",
                             e.req, out_data, out_sop, out_eop, out_len,
                             e.data, e.sop, e.eop, e.len);
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check(out_valid == 0 && out_sop == 0 && out_eop == 0, "R1", "flags in reset",
              {out_valid, out_sop, out_eop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_sop == 0 && out_eop == 0, "R1", "flags after reset",
              {out_valid, out_sop, out_eop}, 0);

        // R4: delimiter only, full 9-bit compare, delimiter word in packet
        set_cfg(1, 'h10A, 0, 0);
        send('h003, "R3");
        send('h005, "R4");
        send('h00A, "R4");        // differs only in bit 8
        send('h10A, "R4");
        // R10: delimiter as the first word gives a one-word packet
        send('h10A, "R10");

        // R5: length only, limit 4, with idle gaps (R11)
        set_cfg(0, 0, 1, 4);
        for (int i = 0; i < 8; i++) send(i + 'h20, (i % 2) ? "R11" : "R5", i % 3);

        // R5: limit of zero acts as one
        set_cfg(0, 0, 1, 0);
        send('h31, "R5");
        send('h32, "R10");

        // R6: both rules, delimiter first then length first
        set_cfg(1, 'h055, 1, 5);
        send('h001, "R6");
        send('h002, "R6");
        send('h055, "R6");
        for (int i = 0; i < 6; i++) send('h0C0 + i, "R6");

        // R9: settings changed inside an open packet wait for the next one
        set_cfg(0, 0, 1, 6);
        send('h041, "R9");
        set_cfg(1, 'h042, 1, 2);
        send('h042, "R9");
        send('h043, "R9");
        send('h044, "R9");
        send('h045, "R9");
        send('h046, "R9");
        send('h042, "R9");        // new packet with delimiter 0x42: one word
        send('h050, "R9");
        send('h051, "R9");        // limit 2

        // R7: both rules off, plain pass-through
        set_cfg(0, 'h042, 0, 2);
        for (int i = 0; i < 4; i++) send('h042 + i, "R7", i % 2);

        // R8: saturation of the position count
        set_cfg(1, 'h1FF, 0, 0);
        for (int i = 0; i < CNT_MAX + 20; i++) send(i % 'h100, "R8");
        send('h1FF, "R8");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "words missing at output", exp_q.size(), 0);
        finish_run();
    end

endmodule